// File: doc/BRIEF.md
# Serial Register File to Word RAM Bridge

This block sits between a bit-serial processor datapath and a single-port RAM that holds the register file. The datapath moves whole 32-bit registers one bit per clock. It can read two registers at once and write two registers at once. The bridge packs the incoming write bits into RAM-width words and unpacks RAM words into outgoing read bits. All four serial streams share one RAM port, and a small phase schedule decides which stream uses the port in each cycle.

A transfer starts with a one-cycle read or write request. The bridge answers with a one-cycle `ready` pulse. After that pulse, 32 bits move on each channel, one per cycle, least significant bit first. Register addresses are five bits wide, with one more bit when CSR storage is enabled, so the CSRs share the same RAM. Register 0 always reads as zero and is never written.

Top module: `regfile_ram_bridge`

## Requirements
- R1: Register `r` occupies 32/RAM_W consecutive RAM words at address `{r, k}`, with the word index `k` in the low bits. Word `k` holds register bits `k*RAM_W` to `k*RAM_W+RAM_W-1`, and register bit `k*RAM_W` sits in RAM data bit 0.
- R2: A read request accepted while idle produces `ready` two cycles later. Bit `b` (b = 0 to 31) of each read register then appears on `rd_bit0`/`rd_bit1` in cycle 3+b after the request, least significant bit first.
- R3: A write request accepted while idle produces `ready` one cycle later. Bit `b` is sampled from `wr_bit0`/`wr_bit1` in cycle 2+b after the request, least significant bit first.
- R4: Every written word reaches the RAM, and the RAM port performs at most one access per cycle. Data written and then read back is identical on both channels.
- R5: The write enable of a channel is sampled on the last bit of each RAM word. A channel whose enable is low leaves its register unchanged.
- R6: No RAM write is ever issued to register address 0, even when a channel requests one.
- R7: A read of register address 0 returns all zeros, whatever the RAM holds at that address.
- R8: When a read request and a write request arrive together while idle, the read is served and the write request is dropped.
- R9: Requests that arrive while a transfer is running are ignored. They raise no `ready` and do not disturb the running transfer.
- R10: `ready` is low in reset and is a single-cycle pulse.
- R11: With CSR storage enabled, addresses 32 to 63 are separate storage from addresses 0 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Start a two-register read (one-cycle pulse) |
| wr_req | input | 1 | Start a two-register write (one-cycle pulse) |
| ready | output | 1 | Request acknowledged; serial data follows |
| rd_addr0 | input | 5+CSR_EN | Read channel 0 register address, held during the transfer |
| rd_addr1 | input | 5+CSR_EN | Read channel 1 register address, held during the transfer |
| rd_bit0 | output | 1 | Read channel 0 serial data |
| rd_bit1 | output | 1 | Read channel 1 serial data |
| wr_addr0 | input | 5+CSR_EN | Write channel 0 register address, held during the transfer |
| wr_addr1 | input | 5+CSR_EN | Write channel 1 register address, held during the transfer |
| wr_en0 | input | 1 | Write channel 0 enable |
| wr_en1 | input | 1 | Write channel 1 enable |
| wr_bit0 | input | 1 | Write channel 0 serial data |
| wr_bit1 | input | 1 | Write channel 1 serial data |
| ram_addr | output | 5+CSR_EN+log2(32/RAM_W) | RAM word address |
| ram_wdata | output | RAM_W | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | RAM_W | RAM read data, one cycle after the address |

## Verification
The bench builds two copies side by side and drives both with the same stimulus. One copy uses RAM_W = 2 and the other RAM_W = 32, both with CSR storage enabled. The narrow copy fills every port slot during a transfer and depends on the channel-0 holding register to meet its read deadline. This exposes any slip in the slot timing or the word index. The wide copy keeps a whole register in one word, so there is no index field at all, and it checks the edges of the schedule at the first and last cycles.

// File: rtl/rfa_pkg.sv
// Shared constants and types for the serial register file bridge.
package rfa_pkg;
    localparam int REG_BITS = 32;
    localparam int CNT_W    = 6;
    // Last counter value of a read and of a write transfer.
    localparam logic [CNT_W-1:0] RD_LAST = 6'd34;
    localparam logic [CNT_W-1:0] WR_LAST = 6'd35;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/rfa_sequencer.sv
// Transfer sequencer.
// Counts cycles in each read or write transfer and gives out the RAM port
// slots, the load and capture strobes and the RAM word index.
// Assumes RAM_W is a power of two from 2 to 32 and the RAM has one cycle of
// read latency. Requests are accepted only while idle, and reads win ties.
module rfa_sequencer
    import rfa_pkg::*;
#(
    parameter int RAM_W = 2,
    parameter int WIDX  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_req,
    input  logic            wr_req,
    output logic            ready,
    output logic            rd_slot0,
    output logic            rd_slot1,
    output logic            rd_hold_cap,
    output logic            rd_load,
    output logic [WIDX-1:0] rd_word,
    output logic            wr_bit_vld,
    output logic            wr_cap,
    output logic            wr_slot0,
    output logic            wr_slot1,
    output logic [WIDX-1:0] wr_word
);
    localparam int             LW      = $clog2(RAM_W);
    localparam logic [CNT_W-1:0] M6      = CNT_W'(RAM_W - 1);
    localparam logic [CNT_W-1:0] RD1_MAX = CNT_W'(REG_BITS - RAM_W + 1);
    localparam logic [CNT_W-1:0] RD2_MAX = CNT_W'(REG_BITS - RAM_W + 2);
    localparam logic [CNT_W-1:0] WR0_MIN = CNT_W'(RAM_W + 2);
    localparam logic [CNT_W-1:0] WR1_MIN = CNT_W'(RAM_W + 3);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] c;
    logic [CNT_W-1:0] ph0, ph1, ph2, ph3;
    logic             start_rd, start_wr, in_rd, in_wr;

    // Decode a new request while idle; reads take priority.
    always_comb begin
        start_rd = (state == SEQ_IDLE) && rd_req;
        start_wr = (state == SEQ_IDLE) && wr_req && !rd_req;
        in_rd    = (state == SEQ_READ) || start_rd;
        in_wr    = (state == SEQ_WRITE);
        c        = (state == SEQ_IDLE) ? '0 : cnt;
    end

    // Step the transfer state and the cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (start_rd) begin
                        state <= SEQ_READ;
                        cnt   <= 6'd1;
                    end else if (start_wr) begin
                        state <= SEQ_WRITE;
                        cnt   <= 6'd1;
                    end
                end
                SEQ_READ: begin
                    if (cnt == RD_LAST) begin
                        state <= SEQ_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 6'd1;
                    end
                end
                SEQ_WRITE: begin
                    if (cnt == WR_LAST) begin
                        state <= SEQ_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 6'd1;
                    end
                end
                default: begin
                    state <= SEQ_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Work out the phase of the current cycle inside a RAM word, at several offsets.
    always_comb begin
        ph0 = c & M6;
        ph1 = (c - 6'd1) & M6;
        ph2 = (c - 6'd2) & M6;
        ph3 = (c - 6'd3) & M6;
    end

    // Read schedule: ch0 word k is fetched at cycle kW and ch1 at kW+1; both load at kW+2.
    always_comb begin
        rd_slot0    = in_rd && (ph0 == '0) && (c < 6'd32);
        rd_slot1    = in_rd && (c >= 6'd1) && (ph1 == '0) && (c <= RD1_MAX);
        rd_hold_cap = rd_slot1;
        rd_load     = (state == SEQ_READ) && (c >= 6'd2) && (ph2 == '0) && (c <= RD2_MAX);
        rd_word     = rd_slot1 ? WIDX'((c - 6'd1) >> LW) : WIDX'(c >> LW);
    end

    // Write schedule: bits arrive at cycles 2..33; each completed word goes out on ch0 and then on ch1.
    always_comb begin
        wr_bit_vld = in_wr && (c >= 6'd2) && (c <= 6'd33);
        wr_cap     = wr_bit_vld && (ph2 == M6);
        wr_slot0   = in_wr && (c >= WR0_MIN) && (ph2 == '0) && (c <= 6'd34);
        wr_slot1   = in_wr && (c >= WR1_MIN) && (ph3 == '0) && (c <= 6'd35);
        wr_word    = wr_slot1 ? WIDX'(((c - 6'd3) >> LW) - 6'd1)
                              : WIDX'(((c - 6'd2) >> LW) - 6'd1);
    end

    // Acknowledge: read after two cycles, write after one.
    always_comb begin
        ready = ((state == SEQ_READ) && (cnt == 6'd2)) ||
                ((state == SEQ_WRITE) && (cnt == 6'd1));
    end

    // R10
    ready_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    // R3
    wr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && wr_req && !rd_req) |=> ready);
    // R8
    rd_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && rd_req && wr_req) |=> (!ready && state == SEQ_READ));
    // R4
    port_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_slot0, rd_slot1, wr_slot0, wr_slot1}));
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_READ && cnt != RD_LAST) |=> (state == SEQ_READ));
endmodule

// File: rtl/rfa_rd_lane.sv
// Read lane: turns RAM words into a serial bit stream, LSB first.
// With USE_HOLD set, the word is caught in a holding register one cycle
// before it is loaded. This lets a channel whose fetch slot comes first
// share the port with the other channel.
// Assumes the register address stays stable for the whole transfer.
module rfa_rd_lane #(
    parameter int RAM_W    = 2,
    parameter bit USE_HOLD = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RAM_W-1:0] ram_rdata,
    input  logic             hold_cap,
    input  logic             load,
    input  logic             zero_reg,
    output logic             bit_out
);
    logic [RAM_W-1:0] src;
    logic [RAM_W-1:0] shreg;

    generate
        if (USE_HOLD) begin : g_hold
            logic [RAM_W-1:0] hold_q;
            // Catch the fetched word while it is on the RAM data bus.
            always_ff @(posedge clk) begin
                if (!rst_n)        hold_q <= '0;
                else if (hold_cap) hold_q <= ram_rdata;
            end
            assign src = hold_q;
        end else begin : g_direct
            logic unused_cap;
            assign unused_cap = hold_cap;
            assign src        = ram_rdata;
        end
    endgenerate

    // Load a word (forced to zero for register 0), otherwise shift toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)    shreg <= '0;
        else if (load) shreg <= zero_reg ? '0 : src;
        else           shreg <= {1'b0, shreg[RAM_W-1:1]};
    end

    assign bit_out = shreg[0];
endmodule

// File: rtl/rfa_wr_lane.sv
// Write lane: collects serial bits, LSB first, into RAM-width words.
// When a word completes it moves to a holding register together with its
// write permission, and it stays there until the sequencer's slot for it.
// Assumes the address and enable are steady for the final bit of each word.
module rfa_wr_lane #(
    parameter int RAM_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             cap,
    input  logic             bit_in,
    input  logic             en_in,
    input  logic             addr_nonzero,
    output logic [RAM_W-1:0] word_out,
    output logic             word_we
);
    logic [RAM_W-1:0] gather;
    logic [RAM_W-1:0] next_gather;

    assign next_gather = {bit_in, gather[RAM_W-1:1]};

    // Shift each arriving bit in at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)       gather <= '0;
        else if (bit_vld) gather <= next_gather;
    end

    // Latch the finished word and decide whether it may be written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
            word_we  <= 1'b0;
        end else if (cap) begin
            word_out <= next_gather;
            word_we  <= en_in && addr_nonzero;
        end
    end
endmodule

// File: rtl/regfile_ram_bridge.sv
// Serial register file to word RAM bridge (top).
// Connects two serial read channels and two serial write channels to one
// single-port RAM of width RAM_W, which must have one cycle of read latency.
// Register r is stored at RAM words {r, k}. Addresses are 5 bits, plus 1
// when CSR_EN is set. Register 0 reads as zero and is never written.
module regfile_ram_bridge #(
    parameter int RAM_W  = 2,
    parameter int CSR_EN = 1,
    localparam int AW     = 5 + CSR_EN,
    localparam int WIDX   = (RAM_W == 32) ? 1 : $clog2(32 / RAM_W),
    localparam int RAM_AW = AW + ((RAM_W == 32) ? 0 : WIDX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_req,
    output logic              ready,
    input  logic [AW-1:0]     rd_addr0,
    input  logic [AW-1:0]     rd_addr1,
    output logic              rd_bit0,
    output logic              rd_bit1,
    input  logic [AW-1:0]     wr_addr0,
    input  logic [AW-1:0]     wr_addr1,
    input  logic              wr_en0,
    input  logic              wr_en1,
    input  logic              wr_bit0,
    input  logic              wr_bit1,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [RAM_W-1:0]  ram_wdata,
    output logic              ram_we,
    input  logic [RAM_W-1:0]  ram_rdata
);
    logic            rd_slot0, rd_slot1, rd_hold_cap, rd_load;
    logic            wr_bit_vld, wr_cap, wr_slot0, wr_slot1;
    logic [WIDX-1:0] rd_word, wr_word;
    logic [RAM_W-1:0] hold_w0, hold_w1;
    logic            hold_we0, hold_we1;
    logic [AW-1:0]   sel_reg;
    logic [WIDX-1:0] sel_word;

    rfa_sequencer #(.RAM_W(RAM_W), .WIDX(WIDX)) u_seq (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .ready(ready),
        .rd_slot0(rd_slot0), .rd_slot1(rd_slot1), .rd_hold_cap(rd_hold_cap),
        .rd_load(rd_load), .rd_word(rd_word), .wr_bit_vld(wr_bit_vld),
        .wr_cap(wr_cap), .wr_slot0(wr_slot0), .wr_slot1(wr_slot1), .wr_word(wr_word)
    );

    rfa_rd_lane #(.RAM_W(RAM_W), .USE_HOLD(1'b1)) u_rd0 (
        .clk(clk), .rst_n(rst_n), .ram_rdata(ram_rdata), .hold_cap(rd_hold_cap),
        .load(rd_load), .zero_reg(rd_addr0 == '0), .bit_out(rd_bit0)
    );

    rfa_rd_lane #(.RAM_W(RAM_W), .USE_HOLD(1'b0)) u_rd1 (
        .clk(clk), .rst_n(rst_n), .ram_rdata(ram_rdata), .hold_cap(1'b0),
        .load(rd_load), .zero_reg(rd_addr1 == '0), .bit_out(rd_bit1)
    );

    rfa_wr_lane #(.RAM_W(RAM_W)) u_wr0 (
        .clk(clk), .rst_n(rst_n), .bit_vld(wr_bit_vld), .cap(wr_cap), .bit_in(wr_bit0),
        .en_in(wr_en0), .addr_nonzero(wr_addr0 != '0), .word_out(hold_w0), .word_we(hold_we0)
    );

    rfa_wr_lane #(.RAM_W(RAM_W)) u_wr1 (
        .clk(clk), .rst_n(rst_n), .bit_vld(wr_bit_vld), .cap(wr_cap), .bit_in(wr_bit1),
        .en_in(wr_en1), .addr_nonzero(wr_addr1 != '0), .word_out(hold_w1), .word_we(hold_we1)
    );

    // Hand the single RAM port to whichever channel owns this cycle's slot.
    always_comb begin
        sel_reg   = '0;
        sel_word  = '0;
        ram_we    = 1'b0;
        ram_wdata = '0;
        if (rd_slot0) begin
            sel_reg  = rd_addr0;
            sel_word = rd_word;
        end else if (rd_slot1) begin
            sel_reg  = rd_addr1;
            sel_word = rd_word;
        end else if (wr_slot0) begin
            sel_reg   = wr_addr0;
            sel_word  = wr_word;
            ram_we    = hold_we0;
            ram_wdata = hold_w0;
        end else if (wr_slot1) begin
            sel_reg   = wr_addr1;
            sel_word  = wr_word;
            ram_we    = hold_we1;
            ram_wdata = hold_w1;
        end
    end

    generate
        if (RAM_W == 32) begin : g_whole
            logic unused_word;
            assign unused_word = ^sel_word;
            assign ram_addr    = sel_reg;
        end else begin : g_split
            assign ram_addr = {sel_reg, sel_word};
        end
    endgenerate

    // R6
    zero_reg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (sel_reg != '0));
    // R4
    we_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (wr_slot0 || wr_slot1));
endmodule

// File: tb/regfile_ram_bridge_bench.sv
module regfile_ram_bridge_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_req = 1'b0, wr_req = 1'b0;
    logic [5:0] rd_addr0 = '0, rd_addr1 = '0, wr_addr0 = '0, wr_addr1 = '0;
    logic       wr_en0 = 1'b0, wr_en1 = 1'b0, wr_bit0 = 1'b0, wr_bit1 = 1'b0;

    logic        rdy_a, b0_a, b1_a, we_a;
    logic [9:0]  ra_a;
    logic [1:0]  wd_a, rdat_a;
    logic        rdy_b, b0_b, b1_b, we_b;
    logic [5:0]  ra_b;
    logic [31:0] wd_b, rdat_b;

    logic [1:0]  mem_a [0:1023];
    logic [31:0] mem_b [0:63];
    logic [31:0] ref_regs [0:63];

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regfile_ram_bridge #(.RAM_W(2), .CSR_EN(1)) u_regfile_ram_bridge (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .ready(rdy_a),
        .rd_addr0(rd_addr0), .rd_addr1(rd_addr1), .rd_bit0(b0_a), .rd_bit1(b1_a),
        .wr_addr0(wr_addr0), .wr_addr1(wr_addr1), .wr_en0(wr_en0), .wr_en1(wr_en1),
        .wr_bit0(wr_bit0), .wr_bit1(wr_bit1), .ram_addr(ra_a), .ram_wdata(wd_a),
        .ram_we(we_a), .ram_rdata(rdat_a)
    );

    regfile_ram_bridge #(.RAM_W(32), .CSR_EN(1)) u_regfile_ram_bridge_w32 (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .ready(rdy_b),
        .rd_addr0(rd_addr0), .rd_addr1(rd_addr1), .rd_bit0(b0_b), .rd_bit1(b1_b),
        .wr_addr0(wr_addr0), .wr_addr1(wr_addr1), .wr_en0(wr_en0), .wr_en1(wr_en1),
        .wr_bit0(wr_bit0), .wr_bit1(wr_bit1), .ram_addr(ra_b), .ram_wdata(wd_b),
        .ram_we(we_b), .ram_rdata(rdat_b)
    );

    // Behavioural single-port RAMs with one cycle of read latency.
    always @(posedge clk) begin
        if (we_a) mem_a[ra_a] <= wd_a;
        rdat_a <= mem_a[ra_a];
        if (we_b) mem_b[ra_b] <= wd_b;
        rdat_b <= mem_b[ra_b];
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string req, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_rdy(input logic exp, input string req);
        check({31'b0, rdy_a}, {31'b0, exp}, req, "ready W2");
        check({31'b0, rdy_b}, {31'b0, exp}, req, "ready W32");
    endtask

    function automatic logic [31:0] exp_val(input logic [5:0] a);
        return (a == 6'd0) ? 32'h0 : ref_regs[a];
    endfunction

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Read two registers and compare every serial bit against the model.
    task automatic do_read(input logic [5:0] a0, input logic [5:0] a1,
                           input bit collide, input bit poke, input string req);
        logic [31:0] e0, e1;
        e0 = exp_val(a0);
        e1 = exp_val(a1);
        @(negedge clk);
        rd_addr0 = a0; rd_addr1 = a1; rd_req = 1'b1;
        if (collide) begin
            wr_req = 1'b1; wr_addr0 = 6'd5; wr_en0 = 1'b1; wr_bit0 = 1'b1;
        end
        @(negedge clk);
        rd_req = 1'b0; wr_req = 1'b0;
        check_rdy(1'b0, req);
        for (int c = 2; c <= 34; c++) begin
            @(negedge clk);
            check_rdy(c == 2, req);
            if (c >= 3) begin
                check({31'b0, b0_a}, {31'b0, e0[c-3]}, req, "ch0 bit W2");
                check({31'b0, b1_a}, {31'b0, e1[c-3]}, req, "ch1 bit W2");
                check({31'b0, b0_b}, {31'b0, e0[c-3]}, req, "ch0 bit W32");
                check({31'b0, b1_b}, {31'b0, e1[c-3]}, req, "ch1 bit W32");
            end
            if (poke && c == 12) begin rd_req = 1'b1; wr_req = 1'b1; end
            if (poke && c == 13) begin rd_req = 1'b0; wr_req = 1'b0; end
        end
        wr_en0 = 1'b0; wr_bit0 = 1'b0;
    endtask

    // Write two registers serially and update the model.
    task automatic do_write(input logic [5:0] a0, input logic [5:0] a1,
                            input logic en0, input logic en1,
                            input logic [31:0] d0, input logic [31:0] d1);
        @(negedge clk);
        wr_req = 1'b1; wr_addr0 = a0; wr_addr1 = a1; wr_en0 = en0; wr_en1 = en1;
        @(negedge clk);
        wr_req = 1'b0;
        check_rdy(1'b1, "R3");
        for (int b = 0; b < 32; b++) begin
            @(negedge clk);
            wr_bit0 = d0[b]; wr_bit1 = d1[b];
            check_rdy(1'b0, "R10");
        end
        repeat (3) @(negedge clk);
        wr_en0 = 1'b0; wr_en1 = 1'b0; wr_bit0 = 1'b0; wr_bit1 = 1'b0;
        if (en0 && a0 != 6'd0) ref_regs[a0] = d0;
        if (en1 && a1 != 6'd0) ref_regs[a1] = d1;
    endtask

    // Inspect the bench RAM layout for one register.
    task automatic check_layout(input logic [5:0] a, input string req);
        for (int k = 0; k < 16; k++)
            check({30'b0, mem_a[{a, 4'(k)}]}, {30'b0, ref_regs[a][2*k +: 2]}, req, "word W2");
        check(mem_b[a], ref_regs[a], req, "word W32");
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem_a[i] = 2'b00;
        for (int i = 0; i < 64; i++) begin mem_b[i] = 32'h0; ref_regs[i] = 32'h0; end
        repeat (3) @(negedge clk);
        check_rdy(1'b0, "R10");
        rst_n = 1'b1;

        do_write(6'd1, 6'd2, 1'b1, 1'b1, 32'hA5C3_0F96, 32'h1234_5678);
        check_layout(6'd1, "R1");
        check_layout(6'd2, "R1");
        do_read(6'd1, 6'd2, 1'b0, 1'b0, "R2");
        do_read(6'd2, 6'd1, 1'b0, 1'b0, "R4");

        do_write(6'd0, 6'd35, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hDEAD_BEEF);
        check_layout(6'd0, "R6");
        do_read(6'd0, 6'd35, 1'b0, 1'b0, "R6");

        do_write(6'd1, 6'd3, 1'b0, 1'b1, 32'h0, 32'h8000_0001);
        do_read(6'd1, 6'd3, 1'b0, 1'b0, "R5");

        do_write(6'd3, 6'd36, 1'b1, 1'b1, 32'h0F0F_1234, 32'h7654_3210);
        do_read(6'd3, 6'd35, 1'b0, 1'b0, "R11");
        do_read(6'd36, 6'd4, 1'b0, 1'b0, "R11");

        for (int k = 0; k < 16; k++) mem_a[{6'd0, 4'(k)}] = 2'b11;
        mem_b[0] = 32'hFFFF_FFFF;
        do_read(6'd0, 6'd0, 1'b0, 1'b0, "R7");

        do_read(6'd1, 6'd2, 1'b1, 1'b0, "R8");
        do_read(6'd5, 6'd1, 1'b0, 1'b0, "R8");

        do_read(6'd2, 6'd35, 1'b0, 1'b1, "R9");
        do_read(6'd2, 6'd35, 1'b0, 1'b0, "R9");

        for (int i = 0; i < 6; i++)
            do_write(6'(i + 7), 6'(63 - i), 1'b1, 1'b1, $urandom, $urandom);
        for (int i = 0; i < 6; i++)
            do_read(6'(63 - i), 6'(i + 7), 1'b0, 1'b0, "R4");

        report();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        report();
        $finish;
    end
endmodule